// File: doc/BRIEF.md
# Dual-Master Register Write Protection Gate

This block sits between two bus masters and a bank of peripheral control registers. One master is a main processor and the other is a math accelerator. Some registers in the bank are marked as guarded by a per-register map input. Each master has its own unlock flag, which it sets and clears with dedicated open and close strobes. A write to a guarded register from a master lands only while that master's own flag is set. Writes to unguarded registers always land. Opening one master's flag never unlocks guarded registers for the other master.

Each master drives its write requests over a valid/ready stream. A request is accepted on a rising edge where valid and ready are both high. The processor stream is never back-pressured, so `cpu_wr_ready` stays high. The accelerator stream drops ready for as long as the processor presents a request to the same register index in the same cycle. While ready is low, the accelerator must hold its request. The processor request wins that register. The accelerator request is accepted on the first cycle after the conflict clears. Accepted writes show up one cycle later as a per-register write strobe with its data. A refused write leaves the register untouched and raises a one-cycle blocked flag for the master that issued it.

Top module: `wp_gate`

## Requirements
- R1: After reset, both unlock flags are cleared (guarded writes refused), and `reg_we`, `blk_cpu` and `blk_acc` are all low.
- R2: A write accepted to an index below NREG whose `prot_map` bit is 0 asserts `reg_we[index]` in the next cycle, with its data on `reg_wdata[index*DW +: DW]`, whatever the state of the flags.
- R3: A processor write to an index whose `prot_map` bit is 1 asserts `reg_we[index]` in the next cycle only if the processor flag is set. Otherwise no strobe is raised and `blk_cpu` is high in the next cycle.
- R4: An accelerator write to an index whose `prot_map` bit is 1 asserts `reg_we[index]` in the next cycle only if the accelerator flag is set. Otherwise no strobe is raised and `blk_acc` is high in the next cycle.
- R5: An open strobe sets the master's flag and a close strobe clears it. When both strobes come in the same cycle, close wins. A write issued in the same cycle as a strobe is judged on the flag value from before that cycle.
- R6: Each flag affects only its own master. With only the processor flag set, accelerator writes to guarded registers are still refused, and the reverse also holds.
- R7: `cpu_wr_ready` is always 1. `acc_wr_ready` is 0 exactly when both valids are high and the two addresses are equal. In that cycle the processor write is performed and the accelerator request is not consumed.
- R8: A blocked flag is a one-cycle pulse per refused write. It is low in any cycle that does not follow a refused write from that master.
- R9: A write to an address of NREG or above raises no strobe and no blocked flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prot_map | input | NREG | Bit i set marks register i as guarded |
| cpu_open | input | 1 | Sets the processor unlock flag |
| cpu_close | input | 1 | Clears the processor unlock flag |
| acc_open | input | 1 | Sets the accelerator unlock flag |
| acc_close | input | 1 | Clears the accelerator unlock flag |
| cpu_wr_valid | input | 1 | Processor write request valid |
| cpu_wr_ready | output | 1 | Processor write request ready (always 1) |
| cpu_wr_addr | input | AW | Processor register index |
| cpu_wr_data | input | DW | Processor write data |
| acc_wr_valid | input | 1 | Accelerator write request valid |
| acc_wr_ready | output | 1 | Accelerator write request ready |
| acc_wr_addr | input | AW | Accelerator register index |
| acc_wr_data | input | DW | Accelerator write data |
| reg_we | output | NREG | Per-register write strobe |
| reg_wdata | output | NREG*DW | Per-register write data, slice i for register i |
| blk_cpu | output | 1 | Processor write refused in the previous cycle |
| blk_acc | output | 1 | Accelerator write refused in the previous cycle |

## Verification
The bench sweeps every address, including addresses past the register bank, for both masters. It does this under all four flag combinations and under several guard maps, and it checks each strobe, data slice and blocked flag against a model of the rules. A gate that shared one flag between the masters, or that checked a master's access against the other master's flag, would let guarded writes through in the mixed-flag cases. The bench also covers three narrower cases: same-cycle open and close, a write issued in the same cycle as a strobe, and both masters hitting the same register. A design that let open win, applied a strobe one cycle early, or let the accelerator overwrite the processor's data would fail these. Idle cycles after refused writes catch a blocked flag that sticks high. Out-of-range addresses catch decoding that aliases the index into the bank.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    MST_CPU = 1'b0,
    MST_ACC = 1'b1
  } master_e;

  localparam int unsigned NUM_MASTERS = 2;
endpackage

// File: rtl/wp_flag.sv
module wp_flag (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  logic close_i,
  output logic unlocked_o
);
  always_ff @(posedge clk) begin
    if (rst)          unlocked_o <= 1'b0;
    else if (close_i) unlocked_o <= 1'b0;
    else if (open_i)  unlocked_o <= 1'b1;
  end
endmodule

// File: rtl/wp_lane.sv
module wp_lane #(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 4
) (
  input  logic            fire_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NREG-1:0] prot_map_i,
  input  logic            unlocked_i,
  output logic [NREG-1:0] grant_oh_o,
  output logic            refused_o
);
  logic [NREG-1:0] hit_oh;
  logic            guarded;
  logic            allow;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit_oh[i] = fire_i && (addr_i == AW'(i));
  end

  assign guarded    = |(hit_oh & prot_map_i);
  assign allow      = !guarded || unlocked_i;
  assign grant_oh_o = allow ? hit_oh : '0;
  assign refused_o  = guarded && !unlocked_i;
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG-1:0]    prot_map,
  input  logic               cpu_open,
  input  logic               cpu_close,
  input  logic               acc_open,
  input  logic               acc_close,
  input  logic               cpu_wr_valid,
  output logic               cpu_wr_ready,
  input  logic [AW-1:0]      cpu_wr_addr,
  input  logic [DW-1:0]      cpu_wr_data,
  input  logic               acc_wr_valid,
  output logic               acc_wr_ready,
  input  logic [AW-1:0]      acc_wr_addr,
  input  logic [DW-1:0]      acc_wr_data,
  output logic [NREG-1:0]    reg_we,
  output logic [NREG*DW-1:0] reg_wdata,
  output logic               blk_cpu,
  output logic               blk_acc
);
  import wp_pkg::*;

  localparam int unsigned NM = NUM_MASTERS;

  logic [NM-1:0]   open_v, close_v, fire_v, flag_q, refused_v;
  logic [AW-1:0]   addr_v [NM];
  logic [NREG-1:0] grant_v [NM];
  logic            clash;

  assign clash        = cpu_wr_valid && acc_wr_valid && (cpu_wr_addr == acc_wr_addr);
  assign cpu_wr_ready = 1'b1;
  assign acc_wr_ready = !clash;

  assign open_v[MST_CPU]  = cpu_open;
  assign open_v[MST_ACC]  = acc_open;
  assign close_v[MST_CPU] = cpu_close;
  assign close_v[MST_ACC] = acc_close;
  assign fire_v[MST_CPU]  = cpu_wr_valid && cpu_wr_ready;
  assign fire_v[MST_ACC]  = acc_wr_valid && acc_wr_ready;
  assign addr_v[MST_CPU]  = cpu_wr_addr;
  assign addr_v[MST_ACC]  = acc_wr_addr;

  for (genvar m = 0; m < NM; m++) begin : g_mst
    wp_flag flag_i (
      .clk        (clk),
      .rst        (rst),
      .open_i     (open_v[m]),
      .close_i    (close_v[m]),
      .unlocked_o (flag_q[m])
    );
    wp_lane #(.NREG(NREG), .AW(AW)) lane_i (
      .fire_i     (fire_v[m]),
      .addr_i     (addr_v[m]),
      .prot_map_i (prot_map),
      .unlocked_i (flag_q[m]),
      .grant_oh_o (grant_v[m]),
      .refused_o  (refused_v[m])
    );
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        reg_we[i]            <= 1'b0;
        reg_wdata[i*DW +: DW] <= '0;
      end else begin
        reg_we[i] <= grant_v[MST_CPU][i] || grant_v[MST_ACC][i];
        if (grant_v[MST_CPU][i])      reg_wdata[i*DW +: DW] <= cpu_wr_data;
        else if (grant_v[MST_ACC][i]) reg_wdata[i*DW +: DW] <= acc_wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cpu <= 1'b0;
      blk_acc <= 1'b0;
    end else begin
      blk_cpu <= refused_v[MST_CPU];
      blk_acc <= refused_v[MST_ACC];
    end
  end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] prot_map,
  input logic            cpu_close,
  input logic            acc_close,
  input logic            cpu_wr_valid,
  input logic [AW-1:0]   cpu_wr_addr,
  input logic            acc_wr_valid,
  input logic            acc_wr_ready,
  input logic [AW-1:0]   acc_wr_addr,
  input logic [NREG-1:0] reg_we,
  input logic            blk_cpu,
  input logic            blk_acc,
  input logic [1:0]      flags
);
  logic            p_rst;
  logic            p_cfree;
  logic            p_cout;
  logic            p_cdeny;
  logic            p_cfire;
  logic            p_afire;
  logic [NREG-1:0] p_coh;

  always_ff @(posedge clk) begin
    p_rst   <= rst;
    p_cfree <= cpu_wr_valid && (cpu_wr_addr < AW'(NREG)) &&
               !(|((NREG'(1) << cpu_wr_addr) & prot_map));
    p_cout  <= cpu_wr_valid && !acc_wr_valid && (cpu_wr_addr >= AW'(NREG));
    p_cdeny <= !flags[0];
    p_cfire <= cpu_wr_valid;
    p_afire <= acc_wr_valid && acc_wr_ready;
    p_coh   <= NREG'(1) << cpu_wr_addr;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    p_rst |-> (reg_we == '0 && !blk_cpu && !blk_acc && flags == 2'b00));

  assert_free_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!p_rst && p_cfree) |-> ((reg_we & p_coh) != '0));

  assert_cpu_block_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (!p_rst && blk_cpu) |-> (p_cfire && p_cdeny));

  assert_acc_block_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (!p_rst && blk_acc) |-> p_afire);

  assert_close_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_close || acc_close) |=> ((!cpu_close || !flags[0]) && (!acc_close || !flags[1])));

  assert_clash_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_valid && acc_wr_valid && cpu_wr_addr == acc_wr_addr) |-> !acc_wr_ready);

  assert_out_of_range_R9: assert property (@(posedge clk) disable iff (rst)
    (!p_rst && p_cout) |-> (reg_we == '0 && !blk_cpu));
endmodule

bind wp_gate wp_gate_chk #(.NREG(NREG), .AW(AW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .prot_map     (prot_map),
  .cpu_close    (cpu_close),
  .acc_close    (acc_close),
  .cpu_wr_valid (cpu_wr_valid),
  .cpu_wr_addr  (cpu_wr_addr),
  .acc_wr_valid (acc_wr_valid),
  .acc_wr_ready (acc_wr_ready),
  .acc_wr_addr  (acc_wr_addr),
  .reg_we       (reg_we),
  .blk_cpu      (blk_cpu),
  .blk_acc      (blk_acc),
  .flags        (flag_q)
);

// File: tb/wp_gate_tb_top.sv
module wp_gate_tb_top;
  localparam int NREG = 8;
  localparam int AW   = 4;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst;
  logic [NREG-1:0] pm;
  logic c_open, c_close, a_open, a_close;
  logic cv, av, c_rdy, a_rdy;
  logic [AW-1:0] ca, aa;
  logic [DW-1:0] cd, ad;
  logic [NREG-1:0] we;
  logic [NREG*DW-1:0] wd;
  logic bc, ba;

  int checks = 0;
  int errors = 0;
  logic m_cf = 1'b0;
  logic m_af = 1'b0;
  logic [NREG-1:0] sweep_maps [3];

  always #10 clk = ~clk;

  wp_gate #(.NREG(NREG), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .prot_map(pm),
    .cpu_open(c_open), .cpu_close(c_close), .acc_open(a_open), .acc_close(a_close),
    .cpu_wr_valid(cv), .cpu_wr_ready(c_rdy), .cpu_wr_addr(ca), .cpu_wr_data(cd),
    .acc_wr_valid(av), .acc_wr_ready(a_rdy), .acc_wr_addr(aa), .acc_wr_data(ad),
    .reg_we(we), .reg_wdata(wd), .blk_cpu(bc), .blk_acc(ba)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: cmd = {cpu_open, cpu_close, acc_open, acc_close}
  task automatic step(input string req, input logic [3:0] cmd,
                      input logic icv, input logic [AW-1:0] ica, input logic [DW-1:0] icd,
                      input logic iav, input logic [AW-1:0] iaa, input logic [DW-1:0] iad);
    logic e_ar, c_in, a_in, c_pr, a_pr, c_ok, a_ok, e_bc, e_ba;
    logic [NREG-1:0] e_we;
    @(negedge clk);
    {c_open, c_close, a_open, a_close} = cmd;
    cv = icv; ca = ica; cd = icd; av = iav; aa = iaa; ad = iad;
    e_ar = !(icv && iav && ica == iaa);
    c_in = icv && (int'(ica) < NREG);
    a_in = iav && e_ar && (int'(iaa) < NREG);
    c_pr = c_in && pm[ica[2:0]];
    a_pr = a_in && pm[iaa[2:0]];
    c_ok = c_in && (!c_pr || m_cf);
    a_ok = a_in && (!a_pr || m_af);
    e_bc = c_pr && !m_cf;
    e_ba = a_pr && !m_af;
    e_we = '0;
    if (c_ok) e_we[ica[2:0]] = 1'b1;
    if (a_ok) e_we[iaa[2:0]] = 1'b1;
    #1;
    chk(req, "cpu_wr_ready", 32'(c_rdy), 32'd1);
    chk(req, "acc_wr_ready", 32'(a_rdy), 32'(e_ar));
    @(posedge clk);
    if (cmd[2]) m_cf = 1'b0; else if (cmd[3]) m_cf = 1'b1;
    if (cmd[0]) m_af = 1'b0; else if (cmd[1]) m_af = 1'b1;
    @(negedge clk);
    {c_open, c_close, a_open, a_close} = 4'b0;
    cv = 1'b0; av = 1'b0;
    chk(req, "reg_we", 32'(we), 32'(e_we));
    chk(req, "blk_cpu", 32'(bc), 32'(e_bc));
    chk(req, "blk_acc", 32'(ba), 32'(e_ba));
    if (c_ok) chk(req, "cpu data", 32'(wd[int'(ica)*DW +: DW]), 32'(icd));
    if (a_ok && !(c_ok && ica == iaa)) chk(req, "acc data", 32'(wd[int'(iaa)*DW +: DW]), 32'(iad));
  endtask

  task automatic idle(input string req);
    step(req, 4'b0000, 1'b0, '0, '0, 1'b0, '0, '0);
  endtask

  initial begin
    {c_open, c_close, a_open, a_close} = 4'b0;
    cv = 0; av = 0; ca = '0; aa = '0; cd = '0; ad = '0; pm = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed at ports and through a guarded write
    chk("R1", "reg_we", 32'(we), 32'd0);
    chk("R1", "blk_cpu", 32'(bc), 32'd0);
    chk("R1", "blk_acc", 32'(ba), 32'd0);
    pm = 8'hFF;
    step("R1", 4'b0000, 1'b1, 4'd2, 16'h1111, 1'b1, 4'd5, 16'h2222);

    // sweep flag states, guard maps, addresses, masters
    sweep_maps[0] = 8'h00; sweep_maps[1] = 8'hFF; sweep_maps[2] = 8'hA5;
    for (int f = 0; f < 4; f++) begin
      step("R5", 4'b0101, 1'b0, '0, '0, 1'b0, '0, '0);
      step("R5", {f[0], 1'b0, f[1], 1'b0}, 1'b0, '0, '0, 1'b0, '0, '0);
      for (int m = 0; m < 3; m++) begin
        pm = sweep_maps[m];
        for (int a = 0; a < 16; a++) begin
          for (int who = 0; who < 2; who++) begin
            string tag;
            if (a >= NREG)            tag = "R9";
            else if (!pm[a % NREG])   tag = "R2";
            else if (f == 1 || f == 2) tag = "R6";
            else if (who == 0)        tag = "R3";
            else                      tag = "R4";
            if (who == 0) step(tag, 4'b0, 1'b1, AW'(a), DW'(16'h3000 + a * 7 + f), 1'b0, '0, '0);
            else          step(tag, 4'b0, 1'b0, '0, '0, 1'b1, AW'(a), DW'(16'h5000 + a * 3 + m));
          end
        end
      end
    end

    // R5: open and close together leaves flags cleared
    pm = 8'hFF;
    step("R5", 4'b1111, 1'b0, '0, '0, 1'b0, '0, '0);
    step("R5", 4'b0000, 1'b1, 4'd1, 16'hAAAA, 1'b1, 4'd3, 16'hBBBB);
    // R5: write in the same cycle as open still judged closed
    step("R5", 4'b1010, 1'b1, 4'd4, 16'hC0C0, 1'b1, 4'd6, 16'hD0D0);
    step("R5", 4'b0000, 1'b1, 4'd4, 16'hC1C1, 1'b1, 4'd6, 16'hD1D1);
    // R5: write in the same cycle as close still judged open
    step("R5", 4'b0101, 1'b1, 4'd0, 16'hE0E0, 1'b1, 4'd7, 16'hF0F0);
    step("R5", 4'b0000, 1'b1, 4'd0, 16'hE1E1, 1'b1, 4'd7, 16'hF1F1);

    // R8: blocked pulse then idle
    step("R8", 4'b0000, 1'b1, 4'd2, 16'h0101, 1'b1, 4'd3, 16'h0202);
    idle("R8");
    step("R8", 4'b0000, 1'b1, 4'd2, 16'h0303, 1'b0, '0, '0);
    step("R8", 4'b0000, 1'b1, 4'd2, 16'h0404, 1'b0, '0, '0);
    idle("R8");

    // R7: collisions on same index, then retry; different indices proceed together
    pm = 8'h00;
    step("R7", 4'b0000, 1'b1, 4'd5, 16'h7777, 1'b1, 4'd5, 16'h8888);
    step("R7", 4'b0000, 1'b0, '0, '0, 1'b1, 4'd5, 16'h8888);
    step("R7", 4'b0000, 1'b1, 4'd1, 16'h1234, 1'b1, 4'd6, 16'h5678);
    step("R7", 4'b0000, 1'b1, 4'd12, 16'h9999, 1'b1, 4'd12, 16'hAAAA);
    pm = 8'hFF;
    step("R7", 4'b0000, 1'b1, 4'd3, 16'h4444, 1'b1, 4'd3, 16'h5555);
    idle("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule